// File: doc/BRIEF.md
# Hybrid Five-Level Phase Modulator

This block turns three phase voltage references into switch commands for a five-level drive on an open-end winding. Each phase winding sits between two two-level inverter legs, each running from half the DC bus. A capacitor-fed H-bridge cell, charged to a quarter of the bus, is in series with the winding. The phase voltage, in quarter-bus units, is twice the A-side leg minus twice the A'-side leg, plus the output of the cell (+1, 0 or -1). That gives the levels -2 to +2.

Each cycle the block adds min-max common-mode injection to the three references. It then compares each shifted reference with four level-shifted triangle carriers. All four carriers come from one up/down counter. The comparison gives each phase a level, and the block picks one of that level's redundant switch states. At the quarter-bus levels the sign of the phase current and a per-phase "capacitor above target" flag decide which state is used, so the cell capacitor is pushed back toward its target. The other levels bypass the capacitor. A clamp input keeps every cell at zero and runs the drive as a three-level dual inverter.

The carrier counter has two named states. In RISE it counts up, and it moves to FALL on the step that reaches the peak. In FALL it counts down, and it moves back to RISE on the step that reaches zero. Reset enters RISE with the count at zero.

Top module: `hfl_modulator`

## Requirements
- R1: While reset is asserted, all gate bits, all levels and the carrier output are zero.
- R2: After reset the carrier output counts 0,1,...,PEAK,PEAK-1,...,1,0,1,... It changes by one on every clock, and one full period is 2*PEAK cycles.
- R3: Each phase reference v is replaced by v - floor((max+min)/2). Here max and min are taken over the three references sampled in the same cycle.
- R4: In normal mode the level of a phase is n-2. Here n counts the k in 0..3 for which the shifted reference is strictly greater than c+(k-2)*PEAK, and c is the carrier count before the edge. The result appears one clock after the inputs. It is a 3-bit two's-complement value in level_o[3p+2:3p], where phase a is p=0, b is p=1 and c is p=2.
- R5: gate_o[4p+3:4p] of phase p is {A-side leg upper switch, A'-side leg upper switch, cell left upper switch, cell right upper switch}. Each lower switch is the complement of its upper switch. The phase level always equals 2*A - 2*A' + left - right.
- R6: Level +2 drives gate bits 1000, level -2 drives 0100 and level 0 drives 0000.
- R7: Level +1 drives 1001 when cap_hi equals cur_neg, and 0010 otherwise. Level -1 drives 0110 when cap_hi differs from cur_neg, and 0001 otherwise. A cell output of +1 (left on, right off) discharges the capacitor when the current is positive (A to A').
- R8: At levels +2, 0 and -2 the current-sign and capacitor flags have no effect on the gates, and the cell left and right bits are equal.
- R9: With clamp high the level is 2*n-2. Here n counts the k in 0..1 for which the shifted reference is greater than 2*c+(2k-2)*PEAK, and both cell bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a_i | input | REF_W | Phase a reference, signed, carrier counts |
| ref_b_i | input | REF_W | Phase b reference, signed |
| ref_c_i | input | REF_W | Phase c reference, signed |
| cur_neg_i | input | 3 | Per phase: 1 when the current flows from A' to A |
| cap_hi_i | input | 3 | Per phase: 1 when the cell capacitor is above its target |
| clamp_i | input | 1 | Hold the cells at zero, three-level operation |
| gate_o | output | 12 | Four upper-switch commands per phase |
| level_o | output | 9 | Chosen level per phase, 3-bit signed |
| carrier_o | output | CW | Carrier counter value |

## Verification
All results come from a single register stage. Levels and gates are due on the edge after the inputs are driven, and they are computed from the carrier count that was present before that edge. The carrier output is due on that same edge and advances by one. The bench keeps its own counter model, drives the inputs at a falling edge, and records the model count. It then lets one rising edge pass and compares the outputs at the next falling edge. Random references are mixed with directed ones that land exactly on a carrier value, lie past both carrier extremes, or fall in clamp mode.

// File: rtl/hfl_pkg.sv
package hfl_pkg;
    typedef enum logic {CAR_RISE, CAR_FALL} car_dir_e;
    typedef logic signed [2:0] lvl_t;
    typedef struct packed {
        logic up_a;
        logic up_b;
        logic cell_l;
        logic cell_r;
    } gate_t;
endpackage

// File: rtl/hfl_carrier.sv
module hfl_carrier
    import hfl_pkg::*;
#(
    parameter int PEAK = 125000,
    parameter int CW   = $clog2(PEAK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] PK  = CW'(PEAK);
    localparam logic [CW-1:0] ONE = CW'(1);

    car_dir_e      st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CAR_RISE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            CAR_RISE: begin
                cnt_n = cnt_q + ONE;
                if (cnt_q + ONE == PK) st_n = CAR_FALL;
            end
            CAR_FALL: begin
                cnt_n = cnt_q - ONE;
                if (cnt_q == ONE) st_n = CAR_RISE;
            end
        endcase
    end

    assign cnt_o = cnt_q;

    a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PK);
    a_r2_peak_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == PK) |=> (cnt_q == PK - ONE));
    a_r2_floor_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |=> (cnt_q == ONE));
endmodule

// File: rtl/hfl_level.sv
module hfl_level
    import hfl_pkg::*;
#(
    parameter int REF_W = 20,
    parameter int PEAK  = 125000,
    parameter int CW    = $clog2(PEAK + 1)
) (
    input  logic signed [REF_W:0] ref_i,
    input  logic [CW-1:0]         cnt_i,
    input  logic                  clamp_i,
    output lvl_t                  lvl_o
);
    localparam int EW = ((REF_W + 1 > CW + 2) ? REF_W + 1 : CW + 2) + 2;

    logic signed [EW-1:0] r_ext, c_ext, c2_ext;
    logic [3:0] gt5;
    logic [1:0] gt3;

    assign r_ext  = {{(EW-REF_W-1){ref_i[REF_W]}}, ref_i};
    assign c_ext  = {{(EW-CW){1'b0}}, cnt_i};
    assign c2_ext = c_ext + c_ext;

    for (genvar k = 0; k < 4; k++) begin : g_band
        localparam logic signed [EW-1:0] OFS = EW'((k - 2) * PEAK);
        assign gt5[k] = r_ext > (c_ext + OFS);
    end

    for (genvar k = 0; k < 2; k++) begin : g_wide
        localparam logic signed [EW-1:0] OFS = EW'((2 * k - 2) * PEAK);
        assign gt3[k] = r_ext > (c2_ext + OFS);
    end

    always_comb begin
        int n;
        n = 0;
        if (clamp_i) begin
            for (int k = 0; k < 2; k++) n += int'(gt3[k]);
            lvl_o = lvl_t'(2 * n - 2);
        end else begin
            for (int k = 0; k < 4; k++) n += int'(gt5[k]);
            lvl_o = lvl_t'(n - 2);
        end
    end
endmodule

// File: rtl/hfl_select.sv
module hfl_select
    import hfl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  lvl_t  lvl_i,
    input  logic  cur_neg_i,
    input  logic  cap_hi_i,
    input  logic  clamp_i,
    output gate_t gate_o,
    output lvl_t  lvl_o
);
    gate_t g_n, g_q;
    lvl_t  lvl_q;

    always_comb begin
        g_n = '0;
        unique case (lvl_i)
            3'sd2:  g_n = '{up_a: 1'b1, up_b: 1'b0, cell_l: 1'b0, cell_r: 1'b0};
            -3'sd2: g_n = '{up_a: 1'b0, up_b: 1'b1, cell_l: 1'b0, cell_r: 1'b0};
            3'sd1: begin
                if (cap_hi_i == cur_neg_i)
                    g_n = '{up_a: 1'b1, up_b: 1'b0, cell_l: 1'b0, cell_r: 1'b1};
                else
                    g_n = '{up_a: 1'b0, up_b: 1'b0, cell_l: 1'b1, cell_r: 1'b0};
            end
            -3'sd1: begin
                if (cap_hi_i != cur_neg_i)
                    g_n = '{up_a: 1'b0, up_b: 1'b1, cell_l: 1'b1, cell_r: 1'b0};
                else
                    g_n = '{up_a: 1'b0, up_b: 1'b0, cell_l: 1'b0, cell_r: 1'b1};
            end
            default: g_n = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q   <= '0;
            lvl_q <= '0;
        end else begin
            g_q   <= g_n;
            lvl_q <= lvl_i;
        end
    end

    assign gate_o = g_q;
    assign lvl_o  = lvl_q;

    a_r5_level_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (2 * int'(g_q.up_a) - 2 * int'(g_q.up_b) + int'(g_q.cell_l) - int'(g_q.cell_r))
            == int'(lvl_q));
    a_r8_bypass_cell: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q[0] == 1'b0) |-> (g_q.cell_l == g_q.cell_r));
    a_r9_clamp_cell_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clamp_i) |-> (!g_q.cell_l && !g_q.cell_r));
endmodule

// File: rtl/hfl_modulator.sv
module hfl_modulator
    import hfl_pkg::*;
#(
    parameter int REF_W = 20,
    parameter int PEAK  = 125000,
    parameter int CW    = $clog2(PEAK + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_a_i,
    input  logic signed [REF_W-1:0] ref_b_i,
    input  logic signed [REF_W-1:0] ref_c_i,
    input  logic [2:0]              cur_neg_i,
    input  logic [2:0]              cap_hi_i,
    input  logic                    clamp_i,
    output logic [11:0]             gate_o,
    output logic [8:0]              level_o,
    output logic [CW-1:0]           carrier_o
);
    localparam int NPH = 3;

    logic signed [REF_W-1:0] refs [NPH];
    logic signed [REF_W-1:0] mx, mn;
    logic signed [REF_W:0]   sum, half;
    logic signed [REF_W:0]   adj [NPH];
    logic [CW-1:0]           cnt;

    assign refs[0] = ref_a_i;
    assign refs[1] = ref_b_i;
    assign refs[2] = ref_c_i;

    always_comb begin
        mx = refs[0];
        mn = refs[0];
        for (int p = 1; p < NPH; p++) begin
            if (refs[p] > mx) mx = refs[p];
            if (refs[p] < mn) mn = refs[p];
        end
        sum  = {mx[REF_W-1], mx} + {mn[REF_W-1], mn};
        half = sum >>> 1;
    end

    hfl_carrier #(.PEAK(PEAK), .CW(CW)) car_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        lvl_t  lvl_c, lvl_r;
        gate_t g;

        assign adj[p] = {refs[p][REF_W-1], refs[p]} - half;

        hfl_level #(.REF_W(REF_W), .PEAK(PEAK), .CW(CW)) lvl_i (
            .ref_i   (adj[p]),
            .cnt_i   (cnt),
            .clamp_i (clamp_i),
            .lvl_o   (lvl_c)
        );

        hfl_select sel_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_i     (lvl_c),
            .cur_neg_i (cur_neg_i[p]),
            .cap_hi_i  (cap_hi_i[p]),
            .clamp_i   (clamp_i),
            .gate_o    (g),
            .lvl_o     (lvl_r)
        );

        assign gate_o[4*p +: 4]  = g;
        assign level_o[3*p +: 3] = lvl_r;
    end

    assign carrier_o = cnt;
endmodule

// File: tb/hfl_modulator_tb.sv
module hfl_modulator_tb_top;
    localparam int REF_W = 12;
    localparam int PK    = 20;
    localparam int CW    = $clog2(PK + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [REF_W-1:0] ra = '0, rb = '0, rc = '0;
    logic [2:0] cneg = '0, chi = '0;
    logic clamp = 1'b0;
    logic [11:0] gate;
    logic [8:0]  level;
    logic [CW-1:0] car;

    int n_chk = 0, n_fail = 0;
    int m_cnt = 0;
    bit m_up = 1'b1;

    always #2 clk = ~clk;

    hfl_modulator #(.REF_W(REF_W), .PEAK(PK), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_a_i(ra), .ref_b_i(rb), .ref_c_i(rc),
        .cur_neg_i(cneg), .cap_hi_i(chi), .clamp_i(clamp),
        .gate_o(gate), .level_o(level), .carrier_o(car)
    );

    function automatic void chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    function automatic int floor_half(int s);
        return (s >= 0) ? s / 2 : -((1 - s) / 2);
    endfunction

    function automatic int exp_lvl(int v, int c, bit cl);
        int n = 0;
        if (cl) begin
            for (int k = 0; k < 2; k++) if (v > 2 * c + (2 * k - 2) * PK) n++;
            return 2 * n - 2;
        end
        for (int k = 0; k < 4; k++) if (v > c + (k - 2) * PK) n++;
        return n - 2;
    endfunction

    function automatic int exp_gate(int l, bit ng, bit hi);
        case (l)
            2:  return 4'b1000;
            -2: return 4'b0100;
            1:  return (hi == ng) ? 4'b1001 : 4'b0010;
            -1: return (hi != ng) ? 4'b0110 : 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic step(int a, int b, int c, bit [2:0] ng, bit [2:0] hi, bit cl);
        int v[3];
        int mx, mn, h, c0, el, eg;
        int el_a[3], eg_a[3];
        ra = REF_W'(a); rb = REF_W'(b); rc = REF_W'(c);
        cneg = ng; chi = hi; clamp = cl;
        v[0] = a; v[1] = b; v[2] = c;
        mx = a; mn = a;
        for (int p = 1; p < 3; p++) begin
            if (v[p] > mx) mx = v[p];
            if (v[p] < mn) mn = v[p];
        end
        h = floor_half(mx + mn);
        c0 = m_cnt;
        for (int p = 0; p < 3; p++) begin
            el = exp_lvl(v[p] - h, c0, cl);
            eg = exp_gate(el, ng[p], hi[p]);
            if (cl) eg = eg & 4'b1100;
            el_a[p] = el; eg_a[p] = eg;
        end
        @(posedge clk);
        @(negedge clk);
        if (m_up) begin m_cnt++; if (m_cnt == PK) m_up = 1'b0; end
        else begin m_cnt--; if (m_cnt == 0) m_up = 1'b1; end
        chk("R2 carrier", int'(car), m_cnt);
        for (int p = 0; p < 3; p++) begin
            chk(cl ? "R9 clamp level" : "R3/R4 level",
                int'($signed(level[3*p +: 3])), el_a[p]);
            if (cl)
                chk("R9 clamp gates", int'(gate[4*p +: 4]), eg_a[p]);
            else if (el_a[p] == 1 || el_a[p] == -1)
                chk("R7 balance gates", int'(gate[4*p +: 4]), eg_a[p]);
            else
                chk("R6/R8 fixed gates", int'(gate[4*p +: 4]), eg_a[p]);
            chk("R5 level sum", 2 * int'(gate[4*p+3]) - 2 * int'(gate[4*p+2])
                + int'(gate[4*p+1]) - int'(gate[4*p]), int'($signed(level[3*p +: 3])));
        end
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int a, b, c;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 reset gates", int'(gate), 0);
        chk("R1 reset levels", int'(level), 0);
        chk("R1 reset carrier", int'(car), 0);
        rst_n = 1'b1;
        // directed: balanced refs landing exactly on carrier values (R4 equality)
        for (int i = 0; i < 2 * PK + 2; i++) begin
            a = m_cnt + ((i % 4) - 2) * PK;
            step(a, -a, 0, 3'b000, 3'b000, 1'b0);
        end
        // directed: beyond both extremes, all flag combinations (R6, R8)
        for (int i = 0; i < 8; i++) begin
            step(3 * PK, -3 * PK, 0, 3'(i), 3'(7 - i), 1'b0);
            step(0, 0, 0, 3'(i), 3'(i), 1'b0);
        end
        // directed: quarter-bus levels with every sign/flag pair (R7)
        for (int i = 0; i < 4 * PK; i++)
            step(PK / 2 + m_cnt / 4, -(PK / 2) - m_cnt / 4, 0,
                 3'(i), 3'(i >> 2), 1'b0);
        // random normal mode (R3, R4, R7)
        for (int i = 0; i < 3000; i++) begin
            a = int'($urandom_range(0, 6 * PK)) - 3 * PK;
            b = int'($urandom_range(0, 6 * PK)) - 3 * PK;
            c = int'($urandom_range(0, 6 * PK)) - 3 * PK;
            step(a, b, c, 3'($urandom), 3'($urandom), 1'b0);
        end
        // random clamp mode (R9)
        for (int i = 0; i < 800; i++) begin
            a = int'($urandom_range(0, 6 * PK)) - 3 * PK;
            b = int'($urandom_range(0, 6 * PK)) - 3 * PK;
            c = int'($urandom_range(0, 6 * PK)) - 3 * PK;
            step(a, b, c, 3'($urandom), 3'($urandom), 1'b1);
        end
        // mixed toggling of clamp
        for (int i = 0; i < 400; i++) begin
            a = int'($urandom_range(0, 4 * PK)) - 2 * PK;
            step(a, -a / 2, -a / 3, 3'($urandom), 3'($urandom), i[0]);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule